// File: doc/BRIEF.md
# Channel Address Compaction Unit

This block converts a system address into the address seen by one memory channel. Each combination of rule index and channel index selects a stored setting. The setting holds a signed offset counted in 64 KiB segments, three flags that each squeeze one interleave bit (bit 8, bit 7 or bit 6) out of the address, and a flag that divides the cache-line index by three. A three-way interleave spreads consecutive lines across channels, so each channel holds only every third line. The divide-by-three packs those lines into a dense range.

Requests enter on a valid/ready stream that carries the address, the rule index and the channel index. Results leave on a second valid/ready stream. The input side applies back-pressure while a request is in flight: `in_ready` is high only when the unit is idle. The output side holds `out_valid` and `out_addr` unchanged until `out_ready` is seen high at a clock edge. When the divide flag is clear, a request takes one cycle. When the flag is set, a bit-serial divider adds one cycle per quotient bit.

A plain `force_ch0` input selects the channel-0 setting for every request. It is meant for paired-channel operating modes, where the channels are run together or as mirror copies of each other. Settings are loaded through an indexed write port. After reset every setting is zero.

Top module: `chan_addr_compact`

## Requirements
- R1: The sum of address bits [39:16] and the sign-extended offset is placed at bit 16 and up. Address bits [15:6] are kept in place, and bits [5:0] of the intermediate result are zero.
- R2: The squeeze steps run in a fixed order: bit 8 when its flag is set, then bit 7, then bit 6. Each step moves every bit above the squeezed position down one place and leaves the lower bits unchanged.
- R3: After the squeeze steps the result is cut to its low 37 bits. A negative offset that wraps the sum therefore leaves ones only up to bit 36.
- R4: With the divide flag set, bits [36:6] are replaced by their integer quotient by 3 and bits [5:0] are kept.
- R5: While `force_ch0` is high, the setting of channel 0 for the given rule is used, whatever `in_chan` is.
- R6: A write with `cfg_we` high stores the offset and the four flags at (`cfg_rule`, `cfg_chan`). After reset every setting is zero, so an address passes through with only the low-bit clearing and the 37-bit cut applied.
- R7: `in_ready` is high exactly when the unit is idle. A request is taken at an edge where `in_valid` and `in_ready` are both high. While a divide runs, `in_ready` stays low and any request offered is not taken.
- R8: Once `out_valid` is high, it and `out_addr` hold steady until an edge with `out_ready` high. The unit then returns to idle.
- R9: The setting is captured at the edge where the request is taken. A write to the same setting at that same edge does not affect that request, but it does apply to later requests.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_ch0 | input | 1 | Use the channel-0 setting for all requests |
| cfg_we | input | 1 | Setting write strobe |
| cfg_rule | input | 3 | Rule index of the write |
| cfg_chan | input | 2 | Channel index of the write |
| cfg_offset | input | 10 | Signed offset in 64 KiB units |
| cfg_rm6 | input | 1 | Squeeze out bit 6 |
| cfg_rm7 | input | 1 | Squeeze out bit 7 |
| cfg_rm8 | input | 1 | Squeeze out bit 8 |
| cfg_div3 | input | 1 | Divide line index by three |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_addr | input | 40 | System address |
| in_rule | input | 3 | Rule index |
| in_chan | input | 2 | Channel index |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_addr | output | 37 | Channel address |

## Verification
The two functions that can coincide are a setting write and the taking of a request that reads the same setting. The bench provokes this by raising `cfg_we` and `in_valid` in the same cycle, with the same rule and channel. In that cycle it also clears the divide flag that the request is about to use. The result is judged correct when it still shows the divide by three. The next request to that setting must then pass through undivided. A second overlap also gets its own check: a new request is offered while a divide is in progress. The bench checks that `in_ready` stays low, that the first result is unchanged, and that the waiting request completes afterwards.

// File: rtl/cac_pkg.sv
package cac_pkg;
  localparam int LINE_B = 6;   // cache-line offset bits
  localparam int SEG_B  = 16;  // offset granule (64 KiB)

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_OUT} cac_state_e;

  typedef struct packed {
    logic rm6;
    logic rm7;
    logic rm8;
    logic div3;
  } cac_flags_t;
endpackage

// File: rtl/cac_cfg_bank.sv
module cac_cfg_bank
  import cac_pkg::*;
#(
  parameter int OFF_W   = 10,
  parameter int N_RULES = 8,
  parameter int N_CHAN  = 3,
  localparam int RW     = $clog2(N_RULES),
  localparam int CW     = $clog2(N_CHAN),
  localparam int N_ENT  = N_RULES * N_CHAN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RW-1:0]    wr_rule,
  input  logic [CW-1:0]    wr_chan,
  input  logic [OFF_W-1:0] wr_off,
  input  cac_flags_t       wr_flags,
  input  logic [RW-1:0]    rd_rule,
  input  logic [CW-1:0]    rd_chan,
  output logic [OFF_W-1:0] rd_off,
  output cac_flags_t       rd_flags
);
  logic [OFF_W-1:0] off_q   [N_ENT];
  cac_flags_t       flags_q [N_ENT];

  function automatic int ent(input logic [RW-1:0] r, input logic [CW-1:0] c);
    return int'(r) * N_CHAN + int'(c);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        off_q[i]   <= '0;
        flags_q[i] <= '0;
      end
    end else if (we && int'(wr_chan) < N_CHAN && int'(wr_rule) < N_RULES) begin
      off_q[ent(wr_rule, wr_chan)]   <= wr_off;
      flags_q[ent(wr_rule, wr_chan)] <= wr_flags;
    end
  end

  always_comb begin
    rd_off   = '0;
    rd_flags = '0;
    if (int'(rd_chan) < N_CHAN && int'(rd_rule) < N_RULES) begin
      rd_off   = off_q[ent(rd_rule, rd_chan)];
      rd_flags = flags_q[ent(rd_rule, rd_chan)];
    end
  end
endmodule

// File: rtl/cac_squeeze.sv
module cac_squeeze
  import cac_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int CADDR_W = 37,
  parameter int OFF_W   = 10,
  localparam int HW     = ADDR_W - SEG_B,
  localparam int NSTEP  = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [OFF_W-1:0]   offset,
  input  cac_flags_t         flags,
  output logic [CADDR_W-1:0] caddr
);
  logic [HW-1:0]     off_ext;
  logic [HW-1:0]     seg_sum;
  logic [ADDR_W-1:0] stage [NSTEP+1];
  logic [NSTEP-1:0]  rm_vec;

  assign off_ext = {{(HW-OFF_W){offset[OFF_W-1]}}, offset};
  assign seg_sum = addr[ADDR_W-1:SEG_B] + off_ext;
  assign stage[0] = {seg_sum, addr[SEG_B-1:LINE_B], addr[LINE_B-1:0] & {LINE_B{1'b0}}};
  // step 0 squeezes bit 8, step 1 bit 7, step 2 bit 6
  assign rm_vec = {flags.rm6, flags.rm7, flags.rm8};

  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    localparam int POS = LINE_B + NSTEP - 1 - g;
    localparam logic [ADDR_W-1:0] LOWM = (ADDR_W'(1) << POS) - ADDR_W'(1);
    assign stage[g+1] = rm_vec[g] ? (((stage[g] >> 1) & ~LOWM) | (stage[g] & LOWM))
                                  : stage[g];
  end

  assign caddr = stage[NSTEP][CADDR_W-1:0];
endmodule

// File: rtl/cac_div3.sv
module cac_div3 #(
  parameter int QW   = 31,
  localparam int CNW = $clog2(QW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [QW-1:0] dividend,
  output logic          done,
  output logic [QW-1:0] quot
);
  logic [QW-1:0]  sh_q;
  logic [1:0]     rem_q;
  logic [CNW-1:0] cnt_q;
  logic           run_q;
  logic [2:0]     trial;
  logic           qbit;

  assign trial = {rem_q, sh_q[QW-1]};
  assign qbit  = (trial >= 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh_q  <= dividend;
        rem_q <= '0;
        cnt_q <= CNW'(QW);
        run_q <= 1'b1;
      end else if (run_q) begin
        sh_q  <= {sh_q[QW-2:0], qbit};
        rem_q <= qbit ? 2'(trial - 3'd3) : trial[1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quot = sh_q;
endmodule

// File: rtl/chan_addr_compact.sv
module chan_addr_compact
  import cac_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int CADDR_W = 37,
  parameter int OFF_W   = 10,
  parameter int N_RULES = 8,
  parameter int N_CHAN  = 3,
  localparam int RW     = $clog2(N_RULES),
  localparam int CW     = $clog2(N_CHAN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               force_ch0,
  input  logic               cfg_we,
  input  logic [RW-1:0]      cfg_rule,
  input  logic [CW-1:0]      cfg_chan,
  input  logic [OFF_W-1:0]   cfg_offset,
  input  logic               cfg_rm6,
  input  logic               cfg_rm7,
  input  logic               cfg_rm8,
  input  logic               cfg_div3,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [RW-1:0]      in_rule,
  input  logic [CW-1:0]      in_chan,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CADDR_W-1:0] out_addr
);
  localparam int QW = CADDR_W - LINE_B;

  cac_state_e         state_q;
  logic [CW-1:0]      sel_chan;
  logic [OFF_W-1:0]   sel_off;
  cac_flags_t         sel_flags;
  cac_flags_t         wr_flags;
  logic [CADDR_W-1:0] sq_addr;
  logic [CADDR_W-1:0] res_q;
  logic [LINE_B-1:0]  low_q;
  logic               take;
  logic               div_start;
  logic               div_done;
  logic [QW-1:0]      div_q;

  assign sel_chan = force_ch0 ? '0 : in_chan;
  assign wr_flags = '{rm6: cfg_rm6, rm7: cfg_rm7, rm8: cfg_rm8, div3: cfg_div3};

  cac_cfg_bank #(.OFF_W(OFF_W), .N_RULES(N_RULES), .N_CHAN(N_CHAN)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wr_rule  (cfg_rule),
    .wr_chan  (cfg_chan),
    .wr_off   (cfg_offset),
    .wr_flags (wr_flags),
    .rd_rule  (in_rule),
    .rd_chan  (sel_chan),
    .rd_off   (sel_off),
    .rd_flags (sel_flags)
  );

  cac_squeeze #(.ADDR_W(ADDR_W), .CADDR_W(CADDR_W), .OFF_W(OFF_W)) u_sq (
    .addr   (in_addr),
    .offset (sel_off),
    .flags  (sel_flags),
    .caddr  (sq_addr)
  );

  assign take      = (state_q == ST_IDLE) && in_valid;
  assign div_start = take && sel_flags.div3;

  cac_div3 #(.QW(QW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (sq_addr[CADDR_W-1:LINE_B]),
    .done     (div_done),
    .quot     (div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
      low_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          if (sel_flags.div3) begin
            low_q   <= sq_addr[LINE_B-1:0];
            state_q <= ST_DIV;
          end else begin
            res_q   <= sq_addr;
            state_q <= ST_OUT;
          end
        end
        ST_DIV: if (div_done) begin
          res_q   <= {div_q, low_q};
          state_q <= ST_OUT;
        end
        ST_OUT: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_OUT);
  assign out_addr  = res_q;
endmodule

// File: rtl/cac_checker.sv
module cac_checker #(
  parameter int CADDR_W = 37
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [CADDR_W-1:0] out_addr
);
  // R8: result held until consumed
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  // R8: result leaves only through a handshake
  a_r8_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R7: not idle while a result is pending
  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R7: a taken request blocks the input in the next cycle
  a_r7_take: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R4: low line-offset bits of any result are zero
  a_r4_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[5:0] == 6'b0);
endmodule

bind chan_addr_compact cac_checker #(.CADDR_W(CADDR_W)) u_cac_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr)
);

// File: tb/tb_chan_addr_compact.sv
module tb_chan_addr_compact;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        force_ch0 = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_rule = '0;
  logic [1:0]  cfg_chan = '0;
  logic [9:0]  cfg_offset = '0;
  logic        cfg_rm6 = 1'b0, cfg_rm7 = 1'b0, cfg_rm8 = 1'b0, cfg_div3 = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] in_addr = '0;
  logic [2:0]  in_rule = '0;
  logic [1:0]  in_chan = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [36:0] out_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  chan_addr_compact dut (
    .clk, .rst_n, .force_ch0, .cfg_we, .cfg_rule, .cfg_chan, .cfg_offset,
    .cfg_rm6, .cfg_rm7, .cfg_rm8, .cfg_div3, .in_valid, .in_ready, .in_addr,
    .in_rule, .in_chan, .out_valid, .out_ready, .out_addr
  );

  typedef struct packed {
    logic [2:0]  rule;
    logic [1:0]  chan;
    logic        frc;
    logic [39:0] addr;
    logic [36:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 1'b0, 40'h12_3456_789A, 37'h12_3456_7880}, // R1 R3
    '{3'd0, 2'd0, 1'b0, 40'hFF_FFFF_FFFF, 37'h1F_FFFF_FFC0}, // R3
    '{3'd1, 2'd0, 1'b0, 40'h00_0001_0040, 37'h00_0002_0040}, // R1 +1
    '{3'd2, 2'd0, 1'b0, 40'h00_0003_FFC5, 37'h00_0002_FFC0}, // R1 -1
    '{3'd2, 2'd0, 1'b0, 40'h00_0000_0000, 37'h1F_FFFF_0000}, // R3 wrap
    '{3'd3, 2'd0, 1'b0, 40'h00_0000_03C0, 37'h00_0000_01C0}, // R2 bit 8
    '{3'd4, 2'd0, 1'b0, 40'h00_0000_0FC0, 37'h00_0000_01C0}, // R2 all three
    '{3'd5, 2'd0, 1'b0, 40'h00_0000_0280, 37'h00_0000_0100}, // R2 bit 7
    '{3'd6, 2'd0, 1'b0, 40'h00_0000_03C0, 37'h00_0000_0140}, // R4 15/3
    '{3'd6, 2'd0, 1'b0, 40'h00_0000_0280, 37'h00_0000_00C0}, // R4 10/3
    '{3'd6, 2'd0, 1'b0, 40'h1F_FFFF_FFC0, 37'h0A_AAAA_AA80}, // R4 max
    '{3'd7, 2'd0, 1'b0, 40'h00_0000_01C0, 37'h00_0000_0040}, // R2 R4
    '{3'd1, 2'd2, 1'b0, 40'h00_0001_0000, 37'h00_0003_0000}, // R5 own chan
    '{3'd1, 2'd2, 1'b1, 40'h00_0001_0000, 37'h00_0002_0000}  // R5 forced
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [2:0] r, input logic [1:0] c, input logic [9:0] off,
                      input logic m6, input logic m7, input logic m8, input logic d3);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rule = r; cfg_chan = c; cfg_offset = off;
    cfg_rm6 = m6; cfg_rm7 = m7; cfg_rm8 = m8; cfg_div3 = d3;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input logic [2:0] r, input logic [1:0] c, input logic f,
                      input logic [39:0] a, output logic [36:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_rule = r; in_chan = c; force_ch0 = f; in_addr = a; out_ready = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    res = out_addr;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [36:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R10 out_valid", 64'(out_valid), 64'd0);
    check("R10 in_ready", 64'(in_ready), 64'd1);

    xfer(3'd5, 2'd1, 1'b0, 40'hFF_FFFF_FFFF, r);
    check("R6 reset passthrough", 64'(r), 64'h1F_FFFF_FFC0);

    wcfg(3'd1, 2'd0, 10'd1,   0, 0, 0, 0);
    wcfg(3'd1, 2'd2, 10'd2,   0, 0, 0, 0);
    wcfg(3'd2, 2'd0, 10'h3FF, 0, 0, 0, 0);
    wcfg(3'd3, 2'd0, 10'd0,   0, 0, 1, 0);
    wcfg(3'd4, 2'd0, 10'd0,   1, 1, 1, 0);
    wcfg(3'd5, 2'd0, 10'd0,   0, 1, 0, 0);
    wcfg(3'd6, 2'd0, 10'd0,   0, 0, 0, 1);
    wcfg(3'd7, 2'd0, 10'd0,   1, 0, 0, 1);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].rule, VECS[i].chan, VECS[i].frc, VECS[i].addr, r);
      check($sformatf("R6 vec%0d", i), 64'(r), 64'(VECS[i].exp));
    end
    force_ch0 = 1'b0;

    // R8: hold under back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_rule = 3'd1; in_chan = 2'd0; in_addr = 40'h1_0040;
    @(negedge clk); in_valid = 1'b0;
    check("R8 valid", 64'(out_valid), 64'd1);
    repeat (3) @(negedge clk);
    check("R8 held valid", 64'(out_valid), 64'd1);
    check("R8 held data", 64'(out_addr), 64'h2_0040);
    check("R7 ready low while pending", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 released", 64'(out_valid), 64'd0);

    // R7: request offered during a divide is not taken
    in_valid = 1'b1; in_rule = 3'd6; in_chan = 2'd0; in_addr = 40'h3C0;
    @(negedge clk);
    in_rule = 3'd0; in_addr = 40'hFFC0;
    check("R7 busy in divide", 64'(in_ready), 64'd0);
    repeat (5) @(negedge clk);
    check("R7 still busy", 64'(in_ready), 64'd0);
    while (!out_valid) @(negedge clk);
    check("R7 first result", 64'(out_addr), 64'h140);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    in_valid = 1'b0;
    check("R7 waiting request", 64'(out_addr), 64'hFFC0);
    @(negedge clk);

    // R9: write and take in the same cycle
    in_valid = 1'b1; in_rule = 3'd6; in_chan = 2'd0; in_addr = 40'h3C0;
    cfg_we = 1'b1; cfg_rule = 3'd6; cfg_chan = 2'd0; cfg_offset = '0;
    cfg_rm6 = 0; cfg_rm7 = 0; cfg_rm8 = 0; cfg_div3 = 0;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    while (!out_valid) @(negedge clk);
    check("R9 old setting used", 64'(out_addr), 64'h140);
    xfer(3'd6, 2'd0, 1'b0, 40'h3C0, r);
    check("R9 new setting later", 64'(r), 64'h3C0);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule